// File: doc/BRIEF.md
# Interrupt Acknowledge Read Unit

This block sits on the processor side of an interrupt controller. For a small set of interrupt IDs it keeps pending and active bits, and it takes a group, a priority and a trigger type for each ID from configuration inputs. A register read strobe, with a secure or non-secure attribute, asks the block for the most urgent interrupt that may be signalled.

The read data is combinational and is valid while the strobe is high. It carries either a real interrupt ID or a reserved code. The reserved codes are 1023 when nothing can be signalled and 1022 when the winner belongs to the group that the reader may not take. When the read returns a real ID, that read is the acknowledge. The interrupt turns active on the clock edge that ends the strobe cycle, and an edge-triggered interrupt also loses its pending bit on that edge.

The pending and active vectors are outputs, so that an end-of-interrupt partner can use them. Software-generated interrupts are IDs 0 to NUM_SGI-1. They report the number of the source processor next to the ID.

Top module: `irq_ack_unit`

## Requirements
- R1: While rst_n is low, and after it is released, pend_o and act_o are all zero. With both enables high, a strobed read then returns 1023 until some interrupt becomes pending.
- R2: rd_data bits 31:13 are always zero. For a granted ID below NUM_SGI, bits 12:10 carry that ID's 3-bit slice of sgi_src (slice j at bits 3j+2:3j). For any other granted ID, bits 12:10 are zero. Bits 9:0 carry the ID.
- R3: When dist_en or cpu_en is low, a read returns 1023 and leaves pend_o and act_o as they would be without the read.
- R4: The candidates are the IDs that are pending, not active, and whose priority value is strictly below prio_mask. The lowest priority value wins, and a tie goes to the lowest ID. With no candidate, the read returns 1023.
- R5: A read that returns a real ID sets that ID's act_o bit on the closing clock edge. An active bit stays set until reset. An edge-triggered ID also clears its pending bit on that edge, unless a new rising edge is seen in the same cycle.
- R6: A level-sensitive ID (trig_edge bit 0) has a pending bit equal to its input as sampled at the previous clock edge. So its pending state persists through an acknowledge while the input stays high.
- R7: An edge-triggered ID (trig_edge bit 1) becomes pending on the edge after its input rises from 0 to 1. The previous input value is held in a register, and that register is cleared by reset.
- R8: With sec_off low, a non-secure read (rd_secure=0) whose winner is group 0 (grp_one bit 0) returns 1023 and changes no state.
- R9: A read whose winner is group 1 returns 1022 and changes no state in two cases: when the read is secure with sec_off low, and for any read when sec_off is high.
- R10: A real ID returned by a read is always below NUM_IRQ, and so is never in the reserved range 1020 to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| trig_edge | input | NUM_IRQ | 1: edge-triggered, 0: level-sensitive |
| grp_one | input | NUM_IRQ | 1: group 1, 0: group 0 |
| prio_cfg | input | NUM_IRQ*PRIO_W | Priority value of ID i at bits i*PRIO_W upward |
| sgi_src | input | NUM_SGI*3 | Source processor number for each software-generated ID |
| dist_en | input | 1 | Distributor forwarding enable |
| cpu_en | input | 1 | Processor signalling enable |
| sec_off | input | 1 | Single security state |
| prio_mask | input | PRIO_W | Priority threshold; a value must be strictly below it |
| rd_stb | input | 1 | Acknowledge register read strobe |
| rd_secure | input | 1 | Security attribute of the read |
| rd_data | output | 32 | Read data |
| pend_o | output | NUM_IRQ | Pending bits |
| act_o | output | NUM_IRQ | Active bits |

## Verification
The bench uses NUM_IRQ=8, PRIO_W=4 and NUM_SGI=2. Eight IDs, each drawing a 4-bit priority at random, produce frequent priority ties and mask-boundary cases. Two software-generated IDs are enough to check the source field against ordinary IDs. A periodic reset clears the active bits that pile up, so selection keeps meeting mixed level and edge IDs in both groups, under every combination of read view and enable.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ID_FIELD_W   = 10;
  localparam int unsigned SRC_W        = 3;
  localparam int unsigned SRC_LSB      = 10;
  localparam int unsigned ID_RSVD_LO   = 1020;
  localparam logic [ID_FIELD_W-1:0] ID_SPURIOUS  = 10'd1023;
  localparam logic [ID_FIELD_W-1:0] ID_WRONG_GRP = 10'd1022;

  typedef enum logic [1:0] {
    RESP_GRANT,
    RESP_SPURIOUS,
    RESP_WRONG_GRP
  } resp_kind_e;
endpackage

// File: rtl/irq_state_cell.sv
module irq_state_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic edge_i,
  input  logic ack_i,
  output logic pend_o,
  output logic act_o
);
  logic pend_q, pend_d;
  logic act_q, act_d;
  logic prev_q;
  logic rise;

  always_comb begin
    rise  = irq_i & ~prev_q;
    act_d = act_q | ack_i;
    if (edge_i) begin
      pend_d = rise | (pend_q & ~ack_i);
    end else begin
      pend_d = irq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      prev_q <= irq_i;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R5
  ack_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> act_q);
  // R5
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q);
  // R7
  edge_rise_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && irq_i && !prev_q) |=> pend_q);
  // R5
  edge_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && ack_i && !(irq_i && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
    assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_i[i] && (!found_o || (prio_arr[i] < prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SGI = 2,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                     found_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     grp_one_i,
  input  logic [NUM_SGI*SRC_W-1:0] sgi_src_i,
  input  logic                     dist_en_i,
  input  logic                     cpu_en_i,
  input  logic                     sec_off_i,
  input  logic                     rd_secure_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     grant_o
);
  resp_kind_e        kind;
  logic [SRC_W-1:0]  src;

  always_comb begin
    if (!(dist_en_i && cpu_en_i) || !found_i) begin
      kind = RESP_SPURIOUS;
    end else if (sec_off_i || rd_secure_i) begin
      kind = grp_one_i ? RESP_WRONG_GRP : RESP_GRANT;
    end else begin
      kind = grp_one_i ? RESP_GRANT : RESP_SPURIOUS;
    end
  end

  always_comb begin
    src = '0;
    for (int j = 0; j < NUM_SGI; j++) begin
      if (idx_i == IDX_W'(j)) src = sgi_src_i[j*SRC_W +: SRC_W];
    end
  end

  always_comb begin
    data_o  = '0;
    grant_o = 1'b0;
    unique case (kind)
      RESP_GRANT: begin
        grant_o = 1'b1;
        data_o[ID_FIELD_W-1:0]        = ID_FIELD_W'(idx_i);
        data_o[SRC_LSB +: SRC_W]      = src;
      end
      RESP_WRONG_GRP: data_o[ID_FIELD_W-1:0] = ID_WRONG_GRP;
      default:        data_o[ID_FIELD_W-1:0] = ID_SPURIOUS;
    endcase
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned NUM_SGI = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IRQ-1:0]          irq_in,
  input  logic [NUM_IRQ-1:0]          trig_edge,
  input  logic [NUM_IRQ-1:0]          grp_one,
  input  logic [NUM_IRQ*PRIO_W-1:0]   prio_cfg,
  input  logic [NUM_SGI*3-1:0]        sgi_src,
  input  logic                        dist_en,
  input  logic                        cpu_en,
  input  logic                        sec_off,
  input  logic [PRIO_W-1:0]           prio_mask,
  input  logic                        rd_stb,
  input  logic                        rd_secure,
  output logic [31:0]                 rd_data,
  output logic [NUM_IRQ-1:0]          pend_o,
  output logic [NUM_IRQ-1:0]          act_o
);
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] ack_vec;
  logic               found;
  logic [IDX_W-1:0]   sel_idx;
  logic [PRIO_W-1:0]  sel_prio;
  logic               grant;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cell
    assign cand[g]    = pend_o[g] & ~act_o[g] &
                        (prio_cfg[g*PRIO_W +: PRIO_W] < prio_mask);
    assign ack_vec[g] = rd_stb & grant & (sel_idx == IDX_W'(g));

    irq_state_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_i  (irq_in[g]),
      .edge_i (trig_edge[g]),
      .ack_i  (ack_vec[g]),
      .pend_o (pend_o[g]),
      .act_o  (act_o[g])
    );
  end

  irq_prio_select #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_sel (
    .cand_i  (cand),
    .prio_i  (prio_cfg),
    .found_o (found),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio)
  );

  irq_ack_resp #(
    .NUM_SGI (NUM_SGI),
    .IDX_W   (IDX_W)
  ) u_resp (
    .found_i     (found),
    .idx_i       (sel_idx),
    .grp_one_i   (grp_one[sel_idx]),
    .sgi_src_i   (sgi_src),
    .dist_en_i   (dist_en),
    .cpu_en_i    (cpu_en),
    .sec_off_i   (sec_off),
    .rd_secure_i (rd_secure),
    .data_o      (rd_data),
    .grant_o     (grant)
  );

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:13] == '0);
  // R3
  disabled_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(dist_en && cpu_en)) |-> (rd_data[9:0] == ID_SPURIOUS && ack_vec == '0));
  // R4
  sel_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (sel_prio < prio_mask && pend_o[sel_idx] && !act_o[sel_idx]));
  // R8
  ns_group0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && found && !sec_off && !rd_secure && !grp_one[sel_idx])
      |=> act_o == $past(act_o));
  // R9
  group1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && found && (sec_off || rd_secure) && grp_one[sel_idx])
      |=> act_o == $past(act_o));
  // R10
  valid_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && grant) |-> (rd_data[9:0] < 10'(NUM_IRQ)));
  // R5
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ack_vec) <= 1);
endmodule

// File: tb/sim_irq_ack_unit.sv
module sim_irq_ack_unit;
  localparam int N    = 8;
  localparam int PW   = 4;
  localparam int NSGI = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_in, trig_edge, grp_one;
  logic [N*PW-1:0] prio_cfg;
  logic [NSGI*3-1:0] sgi_src;
  logic dist_en, cpu_en, sec_off, rd_stb, rd_secure;
  logic [PW-1:0] prio_mask;
  logic [31:0] rd_data;
  logic [N-1:0] pend_o, act_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [N-1:0] m_pend, m_act, m_prev;

  irq_ack_unit #(.NUM_IRQ(N), .PRIO_W(PW), .NUM_SGI(NSGI)) u0 (
    .clk, .rst_n, .irq_in, .trig_edge, .grp_one, .prio_cfg, .sgi_src,
    .dist_en, .cpu_en, .sec_off, .prio_mask, .rd_stb, .rd_secure,
    .rd_data, .pend_o, .act_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected read response from the model; ack_idx = -1 when no acknowledge.
  function automatic logic [31:0] exp_read(output int ack_idx, output string tag);
    int best = -1;
    logic [31:0] d;
    ack_idx = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !m_act[i] && prio_cfg[i*PW +: PW] < prio_mask)
        if (best < 0 || prio_cfg[i*PW +: PW] < prio_cfg[best*PW +: PW]) best = i;
    if (!(dist_en && cpu_en)) begin tag = "R3"; return 32'd1023; end
    if (best < 0) begin tag = "R4"; return 32'd1023; end
    if ((sec_off || rd_secure) && grp_one[best]) begin tag = "R9"; return 32'd1022; end
    if (!sec_off && !rd_secure && !grp_one[best]) begin tag = "R8"; return 32'd1023; end
    ack_idx = best;
    tag = "R4";
    d = 32'(best);
    if (best < NSGI) d[12:10] = sgi_src[best*3 +: 3];
    return d;
  endfunction

  // One clock: check the read (inputs already driven), advance model, check state.
  task automatic step();
    int ai;
    string tag;
    logic [31:0] e;
    logic [N-1:0] rise;
    #1;
    e = exp_read(ai, tag);
    if (rd_stb) begin
      check(tag, rd_data, e);
      // R2
      check("R2", {13'd0, rd_data[31:13]}, 32'd0);
      // R10
      if (ai >= 0) checks++;
      if (ai >= 0 && rd_data[9:0] >= 10'd1020) begin
        errors++;
        $display("FAIL R10: actual %0d expected below 1020", rd_data[9:0]);
      end
    end
    @(posedge clk);
    rise = irq_in & ~m_prev;
    for (int i = 0; i < N; i++) begin
      logic ak;
      ak = rd_stb && (ai == i);
      if (trig_edge[i]) m_pend[i] = rise[i] | (m_pend[i] & ~ak);
      else              m_pend[i] = irq_in[i];
      m_act[i] = m_act[i] | ak;
    end
    m_prev = irq_in;
    @(negedge clk);
    check("R5/R6/R7 pend", 32'(pend_o), 32'(m_pend));
    check("R5 act", 32'(act_o), 32'(m_act));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_pend = '0; m_act = '0; m_prev = '0;
    @(negedge clk);
    // R1
    check("R1 pend", 32'(pend_o), 0);
    check("R1 act", 32'(act_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic set_prio(input int id, input int p);
    prio_cfg[id*PW +: PW] = PW'(p);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    irq_in = '0; trig_edge = '0; grp_one = '0; prio_cfg = '0;
    sgi_src = {3'd6, 3'd5};
    dist_en = 1; cpu_en = 1; sec_off = 0; prio_mask = '1;
    rd_stb = 0; rd_secure = 0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    // R1: read after reset with nothing pending
    rd_stb = 1; rd_secure = 1;
    #1 check("R1 read", rd_data, 32'd1023);
    step();

    // R7, R2: edge SGI 1 from source 6, group 0, secure read
    rd_stb = 0;
    trig_edge = 8'b0000_0010; set_prio(1, 2);
    irq_in[1] = 1; step();
    rd_stb = 1; rd_secure = 1;
    #1 d = rd_data;
    check("R2 sgi", d, (32'd6 << 10) | 32'd1);
    step();
    // R5: edge pending cleared, active set
    check("R5 pend", 32'(pend_o[1]), 0);
    check("R5 act", 32'(act_o[1]), 1);

    // R4 tie: ids 3 and 6 level, same priority, group 1, non-secure
    rd_stb = 0; irq_in = '0; grp_one = 8'b0100_1000;
    set_prio(3, 4); set_prio(6, 4);
    irq_in[3] = 1; irq_in[6] = 1; step();
    rd_stb = 1; rd_secure = 0;
    #1 check("R4 tie", rd_data, 32'd3);
    step();
    // R6: level pending persists after acknowledge
    check("R6 persist", 32'(pend_o[3]), 1);
    // R4 mask boundary: prio 4 with mask 4 -> 1023
    prio_mask = 4'd4;
    #1 check("R4 mask", rd_data, 32'd1023);
    step();
    // R9: secure read of group 1 winner
    prio_mask = '1; rd_secure = 1;
    #1 check("R9 sec", rd_data, 32'd1022);
    step();
    check("R9 nochange", 32'(act_o[6]), 0);
    // R3 disabled
    cpu_en = 0;
    #1 check("R3 off", rd_data, 32'd1023);
    step();
    cpu_en = 1; rd_stb = 0;

    // Random phase
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) begin
        @(negedge clk);
        do_reset();
        trig_edge = N'($urandom);
        grp_one   = N'($urandom);
        prio_cfg  = (N*PW)'({$urandom, $urandom});
        sgi_src   = (NSGI*3)'($urandom);
      end
      for (int i = 0; i < N; i++) if ($urandom_range(0, 4) == 0) irq_in[i] = ~irq_in[i];
      dist_en   = ($urandom_range(0, 9) != 0);
      cpu_en    = ($urandom_range(0, 9) != 0);
      sec_off   = ($urandom_range(0, 3) == 0);
      rd_secure = $urandom_range(0, 1) == 1;
      rd_stb    = $urandom_range(0, 2) == 0;
      prio_mask = PW'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule